// File: doc/BRIEF.md
# Reset Source and Watchdog Supervisor

This block is the single place where the chip reset is made. It merges five reset causes into one active-high system reset: a power-on pulse, a filtered external reset pin, a USB bus reset, a watchdog expiry and a wake from suspend. Any cause keeps the reset asserted, and the reset is then stretched by a fixed number of cycles after the last cause goes away. Two status flags record the kind of the last reset: a power-loss flag that marks a cold start, and a suspend flag that marks a wake from suspend.

Software talks to the block through a simple write bus. Writing the kick value to the watchdog address restarts the watchdog, and nothing else stops or disables it. Writing the first key byte followed directly by the second key byte to a second address puts the chip into suspend. The oscillator enable output then drops and the watchdog freezes until a resume event or a key press wakes the chip with a warm reset. The status flags can be rewritten by software. The analog oscillator and the USB line signalling sit outside this block.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_low` is 1 the block holds `sys_rst`=1, `osc_en`=1 and `mode_flags`=02h. After `supply_low` falls, `sys_rst` stays 1 through clock edge POR_CYC+HOLD_CYC, counted from the first edge that samples `supply_low`=0. It is 0 after edge POR_CYC+HOLD_CYC+1.
- R2: A reset cause that is active at edge k sets `sys_rst` to 1 after edge k. `sys_rst` stays 1 up to and including edge k+HOLD_CYC. If no cause is active after edge k, `sys_rst` is 0 after edge k+HOLD_CYC+1.
- R3: If no valid kick arrives, the watchdog expires and causes a reset. `sys_rst` is still 0 after the WDT_CYC-th edge following its fall and is 1 after the next edge.
- R4: A bus write of 55h to address 0Eh restarts the watchdog count, so expiry moves to WDT_CYC+1 edges after that write. A write of any other value to 0Eh does not change the count.
- R5: A cold reset forces `mode_flags` to 02h, which means POF (bit 1) = 1 and SUSF (bit 0) = 0. The cold causes are power-on, the filtered pin and `usb_rst`.
- R6: A bus write to address 0Fh loads data bit 1 into POF and data bit 0 into SUSF.
- R7: A watchdog reset is warm and leaves POF and SUSF unchanged.
- R8: `ext_rst_n` causes a cold reset only when it is low for PIN_MIN consecutive clock edges, counted after a two-stage synchronizer. Shorter low pulses have no effect.
- R9: Suspend is entered only when a write of AAh to address 1Fh comes directly after a write of 55h to address 1Eh. `osc_en` then reads 0 after the edge that takes the second write. Any other write in between cancels the key.
- R10: While suspended, the watchdog does not count and no watchdog reset occurs.
- R11: While suspended, `resume_evt` or `key_wake` sets `osc_en` back to 1, sets SUSF, leaves POF unchanged and causes a reset. When the chip is not suspended, both inputs are ignored.
- R12: Bus writes are ignored while `sys_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supply_low | input | 1 | Supply below operating level; synchronous active-high block reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| usb_rst | input | 1 | USB bus reset seen, level |
| resume_evt | input | 1 | Resume signalling seen on the bus |
| key_wake | input | 1 | Key press detected while suspended |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register write address |
| bus_wdata | input | 8 | Register write data |
| sys_rst | output | 1 | System reset, active high |
| osc_en | output | 1 | Oscillator enable, 0 while suspended |
| mode_flags | output | 8 | Status byte: bit 1 POF, bit 0 SUSF, other bits 0 |

## Verification
Each reset cause is driven on its own so that both the reset timing and the resulting flag value show which path acted. Power-on, a one-cycle USB reset and pin pulses of 2, 9, 10 and 14 cycles separate cold resets from ignored glitches. The 9 and 10 cycle pulses sit on both sides of the filter threshold. Watchdog runs with no kick, with a wrong kick value and with a correct kick placed mid-period show whether only 55h restarts the count. The suspend key is tried correct, interrupted by a foreign write and with a wrong second byte. Resume and key wake are sent both while suspended and while running, which separates a real wake from an ignored event.

// File: rtl/rstmgr_pkg.sv
package rstmgr_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 8;

    localparam logic [BUS_AW-1:0] WDT_KICK_ADDR  = 8'h0E;
    localparam logic [BUS_AW-1:0] FLAG_ADDR      = 8'h0F;
    localparam logic [BUS_AW-1:0] SUSP_KEY1_ADDR = 8'h1E;
    localparam logic [BUS_AW-1:0] SUSP_KEY2_ADDR = 8'h1F;

    localparam logic [BUS_DW-1:0] WDT_KICK_VAL  = 8'h55;
    localparam logic [BUS_DW-1:0] SUSP_KEY1_VAL = 8'h55;
    localparam logic [BUS_DW-1:0] SUSP_KEY2_VAL = 8'hAA;

    localparam int POF_BIT  = 1;
    localparam int SUSF_BIT = 0;

    typedef struct packed {
        logic              wr;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_wr_t;

    typedef struct packed {
        logic por;
        logic pin;
        logic usb;
        logic wdog;
        logic wake;
    } rst_src_t;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_ARMED = 2'd1,
        PM_SUSP  = 2'd2
    } pm_state_t;

    function automatic logic bus_hit(bus_wr_t b, logic [BUS_AW-1:0] a,
                                     logic [BUS_DW-1:0] v);
        return b.wr && (b.addr == a) && (b.data == v);
    endfunction

    function automatic logic bus_to(bus_wr_t b, logic [BUS_AW-1:0] a);
        return b.wr && (b.addr == a);
    endfunction

    function automatic logic src_cold(rst_src_t s);
        return s.por | s.pin | s.usb;
    endfunction

    function automatic logic src_any(rst_src_t s);
        return s.por | s.pin | s.usb | s.wdog | s.wake;
    endfunction

endpackage

// File: rtl/rstmgr_pin_filter.sv
module rstmgr_pin_filter
    import rstmgr_pkg::*;
#(
    parameter int PIN_MIN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic active
);
    localparam int CW = $clog2(PIN_MIN + 1);

    logic          s1, s2;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= 1'b1;
            s2      <= 1'b1;
            low_cnt <= '0;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            if (s2)
                low_cnt <= '0;
            else if (low_cnt != CW'(PIN_MIN))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign active = (low_cnt == CW'(PIN_MIN));

    // R8
    pin_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(!s2));

endmodule

// File: rtl/rstmgr_wdog.sv
module rstmgr_wdog
    import rstmgr_pkg::*;
#(
    parameter int WDT_CYC = 900000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sys_rst,
    input  logic    halt,
    input  bus_wr_t bus,
    output logic    expire
);
    localparam int CW = $clog2(WDT_CYC + 1);

    logic [CW-1:0] cnt;
    logic          kick;

    assign kick = bus_hit(bus, WDT_KICK_ADDR, WDT_KICK_VAL);

    always_ff @(posedge clk) begin
        if (rst || sys_rst) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else if (halt) begin
            expire <= 1'b0;
        end else if (kick) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else if (cnt == CW'(WDT_CYC - 1)) begin
            cnt    <= '0;
            expire <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            expire <= 1'b0;
        end
    end

    // R3
    wdog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    // R4
    kick_restart_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> !expire);

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (halt && $past(halt)) |-> !expire);

endmodule

// File: rtl/rstmgr_suspend.sv
module rstmgr_suspend
    import rstmgr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sys_rst,
    input  bus_wr_t bus,
    input  logic    wake_req,
    output logic    suspended,
    output logic    wake_hit
);
    pm_state_t state;
    logic      key1, key2;

    assign key1 = bus_hit(bus, SUSP_KEY1_ADDR, SUSP_KEY1_VAL);
    assign key2 = bus_hit(bus, SUSP_KEY2_ADDR, SUSP_KEY2_VAL);

    always_ff @(posedge clk) begin
        if (rst || sys_rst) begin
            state    <= PM_RUN;
            wake_hit <= 1'b0;
        end else begin
            wake_hit <= (state == PM_SUSP) && wake_req;
            case (state)
                PM_RUN:   if (key1) state <= PM_ARMED;
                PM_ARMED: begin
                    if (bus.wr) begin
                        if (key2)      state <= PM_SUSP;
                        else if (key1) state <= PM_ARMED;
                        else           state <= PM_RUN;
                    end
                end
                PM_SUSP:  if (wake_req) state <= PM_RUN;
                default:  state <= PM_RUN;
            endcase
        end
    end

    assign suspended = (state == PM_SUSP);

    // R9
    susp_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(suspended) |-> $past(key2));

    // R11
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        wake_hit |-> !suspended);

endmodule

// File: rtl/rstmgr_flags.sv
module rstmgr_flags
    import rstmgr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cold,
    input  logic    resumed,
    input  bus_wr_t bus,
    output logic    pof,
    output logic    susf
);
    logic flag_wr;
    assign flag_wr = bus_to(bus, FLAG_ADDR);

    always_ff @(posedge clk) begin
        if (rst || cold) begin
            pof  <= 1'b1;
            susf <= 1'b0;
        end else if (resumed) begin
            susf <= 1'b1;
        end else if (flag_wr) begin
            pof  <= bus.data[POF_BIT];
            susf <= bus.data[SUSF_BIT];
        end
    end

    // R5
    cold_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cold |=> (pof && !susf));

    // R11
    resume_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (resumed && !cold) |=> (susf && $stable(pof)));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rstmgr_pkg::*;
#(
    parameter int POR_CYC  = 30000,
    parameter int WDT_CYC  = 900000,
    parameter int PIN_MIN  = 10,
    parameter int HOLD_CYC = 16
) (
    input  logic              clk,
    input  logic              supply_low,
    input  logic              ext_rst_n,
    input  logic              usb_rst,
    input  logic              resume_evt,
    input  logic              key_wake,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              sys_rst,
    output logic              osc_en,
    output logic [7:0]        mode_flags
);
    localparam int POR_W  = $clog2(POR_CYC + 1);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    logic [POR_W-1:0]  por_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    logic              rst_q;
    rst_src_t          src;
    bus_wr_t           bus_g;
    logic              pin_act, wd_exp, susp, wake_hit, pof, susf;

    assign bus_g.wr   = bus_wr & ~rst_q;
    assign bus_g.addr = bus_addr;
    assign bus_g.data = bus_wdata;

    always_ff @(posedge clk) begin
        if (supply_low)
            por_cnt <= POR_W'(POR_CYC);
        else if (por_cnt != '0)
            por_cnt <= por_cnt - 1'b1;
    end

    rstmgr_pin_filter #(.PIN_MIN(PIN_MIN)) u_pin (
        .clk(clk), .rst(supply_low), .pin_n(ext_rst_n), .active(pin_act)
    );

    rstmgr_wdog #(.WDT_CYC(WDT_CYC)) u_wdog (
        .clk(clk), .rst(supply_low), .sys_rst(rst_q), .halt(susp),
        .bus(bus_g), .expire(wd_exp)
    );

    rstmgr_suspend u_susp (
        .clk(clk), .rst(supply_low), .sys_rst(rst_q), .bus(bus_g),
        .wake_req(resume_evt | key_wake), .suspended(susp),
        .wake_hit(wake_hit)
    );

    assign src.por  = (por_cnt != '0);
    assign src.pin  = pin_act;
    assign src.usb  = usb_rst;
    assign src.wdog = wd_exp;
    assign src.wake = wake_hit;

    rstmgr_flags u_flags (
        .clk(clk), .rst(supply_low), .cold(src_cold(src)),
        .resumed(src.wake), .bus(bus_g), .pof(pof), .susf(susf)
    );

    always_ff @(posedge clk) begin
        if (supply_low || src_any(src)) begin
            hold_cnt <= HOLD_W'(HOLD_CYC);
            rst_q    <= 1'b1;
        end else begin
            rst_q <= (hold_cnt != '0);
            if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign sys_rst    = rst_q;
    assign osc_en     = ~susp;
    assign mode_flags = {6'b0, pof, susf};

    // R2
    src_rst_chk: assert property (@(posedge clk) disable iff (supply_low)
        src_any(src) |=> sys_rst);

    // R1
    por_hold_chk: assert property (@(posedge clk) disable iff (supply_low)
        src.por |-> sys_rst);

    // R7
    wdog_warm_chk: assert property (@(posedge clk) disable iff (supply_low)
        (src.wdog && !src_cold(src) && !bus_g.wr) |=> ($stable(pof) && $stable(susf)));

    // R12
    gated_wr_chk: assert property (@(posedge clk) disable iff (supply_low)
        (sys_rst && bus_wr && bus_addr == FLAG_ADDR && !src_any(src))
            |=> ($stable(pof) && $stable(susf)));

endmodule

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
    localparam int POR  = 20;
    localparam int WDT  = 200;
    localparam int PIN  = 10;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       supply_low = 1'b1, ext_rst_n = 1'b1, usb_rst = 1'b0;
    logic       resume_evt = 1'b0, key_wake = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic       sys_rst, osc_en;
    logic [7:0] mode_flags;

    int n_chk = 0, n_bad = 0, cyc = 0;

    rst_supervisor #(.POR_CYC(POR), .WDT_CYC(WDT), .PIN_MIN(PIN), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .supply_low(supply_low), .ext_rst_n(ext_rst_n),
        .usb_rst(usb_rst), .resume_evt(resume_evt), .key_wake(key_wake),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .sys_rst(sys_rst), .osc_en(osc_en), .mode_flags(mode_flags)
    );

    always #2 clk = ~clk;

    // pin low width and whether a reset must follow
    localparam logic [8:0] PIN_VEC [4] = '{
        {8'd2, 1'b0}, {8'd9, 1'b0}, {8'd10, 1'b1}, {8'd14, 1'b1}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_rst_low();
        int g = 0;
        while (sys_rst && g < 2000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    initial begin
        logic seen;
        repeat (5) @(negedge clk);
        check(sys_rst == 1'b1, "R1 rst in supply low", sys_rst, 1);
        check(osc_en == 1'b1, "R1 osc_en in supply low", osc_en, 1);
        check(mode_flags == 8'h02, "R5 flags at power-on", mode_flags, 8'h02);

        supply_low = 1'b0;
        repeat (POR + HOLD) @(negedge clk);
        check(sys_rst == 1'b1, "R1 power-on pulse end-1", sys_rst, 1);
        @(negedge clk);
        check(sys_rst == 1'b0, "R1 power-on release", sys_rst, 0);

        wr(8'h0F, 8'h01);
        check(mode_flags == 8'h01, "R6 flag write", mode_flags, 8'h01);
        wr(8'h0F, 8'h00);

        // R2 / R5 / R12: one-cycle usb reset
        usb_rst = 1'b1;
        @(negedge clk);
        usb_rst = 1'b0;
        check(sys_rst == 1'b1, "R2 usb reset rise", sys_rst, 1);
        check(mode_flags == 8'h02, "R5 usb reset cold", mode_flags, 8'h02);
        wr(8'h0F, 8'h00);
        check(mode_flags == 8'h02, "R12 write during reset", mode_flags, 8'h02);
        repeat (HOLD - 1) @(negedge clk);
        check(sys_rst == 1'b1, "R2 hold last", sys_rst, 1);
        @(negedge clk);
        check(sys_rst == 1'b0, "R2 hold release", sys_rst, 0);

        // R3 / R7: unkicked watchdog
        wr(8'h0F, 8'h00);
        repeat (WDT - 1) @(negedge clk);
        check(sys_rst == 1'b0, "R3 before expiry", sys_rst, 0);
        @(negedge clk);
        check(sys_rst == 1'b1, "R3 expiry reset", sys_rst, 1);
        wait_rst_low();
        check(mode_flags == 8'h00, "R7 watchdog warm", mode_flags, 8'h00);

        // R4: wrong kick value
        wr(8'h0E, 8'h54);
        repeat (WDT - 1) @(negedge clk);
        check(sys_rst == 1'b0, "R4 wrong kick before", sys_rst, 0);
        @(negedge clk);
        check(sys_rst == 1'b1, "R4 wrong kick ignored", sys_rst, 1);
        wait_rst_low();

        // R4: valid kick at edge 100
        repeat (99) @(negedge clk);
        wr(8'h0E, 8'h55);
        repeat (WDT) @(negedge clk);
        check(sys_rst == 1'b0, "R4 kick delays expiry", sys_rst, 0);
        @(negedge clk);
        check(sys_rst == 1'b1, "R4 kicked expiry", sys_rst, 1);
        wait_rst_low();

        // R8: pin pulse table
        for (int i = 0; i < 4; i++) begin
            wr(8'h0E, 8'h55);
            wr(8'h0F, 8'h00);
            ext_rst_n = 1'b0;
            repeat (int'(PIN_VEC[i][8:1])) @(negedge clk);
            ext_rst_n = 1'b1;
            seen = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (sys_rst) seen = 1'b1;
            end
            check(seen == PIN_VEC[i][0], "R8 pin width reset", seen, PIN_VEC[i][0]);
            check(mode_flags == (PIN_VEC[i][0] ? 8'h02 : 8'h00), "R8 pin flags",
                  mode_flags, PIN_VEC[i][0] ? 8'h02 : 8'h00);
            wait_rst_low();
        end

        // R9: key variants
        wr(8'h0F, 8'h00);
        wr(8'h1E, 8'h55); wr(8'h05, 8'h00); wr(8'h1F, 8'hAA);
        check(osc_en == 1'b1, "R9 interrupted key", osc_en, 1);
        wr(8'h1E, 8'h55); wr(8'h1F, 8'hAB);
        check(osc_en == 1'b1, "R9 wrong second byte", osc_en, 1);
        wr(8'h1E, 8'h55); wr(8'h1F, 8'hAA);
        check(osc_en == 1'b0, "R9 suspend entered", osc_en, 0);

        // R10: frozen watchdog
        seen = 1'b0;
        for (int k = 0; k < 2 * WDT; k++) begin
            @(negedge clk);
            if (sys_rst) seen = 1'b1;
        end
        check(seen == 1'b0, "R10 no reset in suspend", seen, 0);

        // R11: resume wake
        resume_evt = 1'b1;
        @(negedge clk);
        resume_evt = 1'b0;
        check(osc_en == 1'b1, "R11 resume osc_en", osc_en, 1);
        @(negedge clk);
        check(sys_rst == 1'b1, "R11 resume reset", sys_rst, 1);
        check(mode_flags == 8'h01, "R11 resume flags", mode_flags, 8'h01);
        wait_rst_low();

        // R11: key wake
        wr(8'h0F, 8'h00);
        wr(8'h1E, 8'h55); wr(8'h1F, 8'hAA);
        key_wake = 1'b1;
        @(negedge clk);
        key_wake = 1'b0;
        @(negedge clk);
        check(sys_rst == 1'b1, "R11 key wake reset", sys_rst, 1);
        check(mode_flags == 8'h01, "R11 key wake flags", mode_flags, 8'h01);
        wait_rst_low();

        // R11: ignored while running
        wr(8'h0F, 8'h00);
        key_wake = 1'b1; resume_evt = 1'b1;
        @(negedge clk);
        key_wake = 1'b0; resume_evt = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (sys_rst) seen = 1'b1;
        end
        check(seen == 1'b0, "R11 wake ignored running", seen, 0);
        check(mode_flags == 8'h00, "R11 flags unchanged running", mode_flags, 8'h00);

        summary();
    end
endmodule